// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block is the interrupt front end of a small 8-bit accumulator CPU. It watches a set of level-sensitive request lines, a software trap request and the global interrupt mask bit. The CPU marks each instruction boundary, and the block samples requests only then. When a request is accepted, the block latches the winner by fixed priority. It then drives five stack-write strobes that save the context, raises the mask-set strobe, and fetches the 16-bit handler address from a fixed table of two-byte vector slots at the top of the address space.

A return-from-interrupt request runs the mirror sequence: five stack reads in the reverse order. Leaving reset runs the vector fetch for the reset slot with no stacking, and a reset in the middle of a sequence abandons it. A separate combinational wake output tells a halted core that a source allowed to end halt is pending. Sources 0 and 1 may always end halt, source 2 may when a configuration input allows it, and the other sources never may.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset is released, the block fetches the reset vector: in the first cycle `vec_rd`=1 with `vec_addr`=FFFEh and `set_i`=1, in the next cycle `vec_addr`=FFFFh, then `busy`=0. No stack access occurs in these cycles.
- R2: Requests are accepted only on a clock edge where `insn_boundary`=1. With `i_mask`=1 and no trap, no sequence starts (`busy` stays 0).
- R3: `sw_trap` starts a sequence even when `i_mask`=1. It outranks every source line and uses vector FFFCh/FFFDh.
- R4: Among pending used sources, the lowest number n wins. Its high vector byte is at FFFAh−2n and its low byte at the next address.
- R5: An entry begins on the cycle after acceptance with five consecutive `stack_wr` cycles. `stack_sel` is 0,1,2,3,4, meaning PC low, PC high, X, A, CC.
- R6: Right after the fifth write, `vec_rd`=1 for two cycles: first the even (high) address with `set_i`=1, then the odd (low) address with `set_i`=0. The block is then idle.
- R7: Request lines whose bit in parameter `USED` is 0 are ignored. With the defaults these are lines 5, 7, 8, 9, 10, 12 and 13.
- R8: The winner is latched at acceptance. Changes on `irq` during the sequence do not alter the fetched vector.
- R9: `iret`=1 while idle starts five consecutive `stack_rd` cycles on the next cycle, with `stack_sel` 4,3,2,1,0. No vector fetch follows, and `iret` takes precedence over a request at the same edge.
- R10: Asserting `rst_n` low during any sequence aborts it. After release, the R1 behaviour follows.
- R11: `wake`=1 only while `halted`=1, and then exactly when `rst_n`=0 or a used line is pending whose wake ability is set. Lines 0 and 1 always have it, line 2 has it when `cfg_src2_wake`=1, and no other line has it by default.
- R12: At most one of `stack_wr`, `stack_rd` and `vec_rd` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the highest-priority source |
| insn_boundary | input | 1 | High for the cycle in which one instruction ends |
| i_mask | input | 1 | Global interrupt mask bit from CC |
| sw_trap | input | 1 | Software trap request at this boundary |
| iret | input | 1 | Return-from-interrupt request |
| irq | input | 14 | Level request lines, bit n is source n |
| halted | input | 1 | Core is in halt |
| cfg_src2_wake | input | 1 | Allows source 2 to end halt |
| busy | output | 1 | A sequence is in progress |
| stack_wr | output | 1 | Stack write strobe |
| stack_rd | output | 1 | Stack read strobe |
| stack_sel | output | 3 | Register selected: 0 PCL, 1 PCH, 2 X, 3 A, 4 CC |
| vec_rd | output | 1 | Vector byte read strobe |
| vec_addr | output | 16 | Vector byte address |
| set_i | output | 1 | Set the I bit in CC |
| wake | output | 1 | Request to leave halt |

## Verification
The bench builds the block with its default parameters: 14 lines, vector top FFFEh, the sparse `USED` map and wake ability on lines 0 and 1 only. With these values, random request patterns that mix used and unused lines exercise the priority pick across the whole table. Requests that touch only unused lines test that such slots are never selected. The configuration input decides the one line whose wake ability changes at run time.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int              NSRC     = 14,
  parameter int              AW       = 16,
  parameter int              NCTX     = 5,
  parameter logic [AW-1:0]   VEC_TOP  = 16'hFFFE,
  parameter logic [NSRC-1:0] USED     = 14'h085F,
  parameter logic [NSRC-1:0] WAKE_SRC = 14'h0003
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_boundary,
  input  logic            i_mask,
  input  logic            sw_trap,
  input  logic            iret,
  input  logic [NSRC-1:0] irq,
  input  logic            halted,
  input  logic            cfg_src2_wake,
  output logic            busy,
  output logic            stack_wr,
  output logic            stack_rd,
  output logic [2:0]      stack_sel,
  output logic            vec_rd,
  output logic [AW-1:0]   vec_addr,
  output logic            set_i,
  output logic            wake
);
  localparam int IW = $clog2(NSRC + 2);
  localparam int CW = 3;

  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_VHI, S_VLO, S_POP} st_t;

  st_t            st;
  logic [IW-1:0]  win, src_idx;
  logic [CW-1:0]  cnt;
  logic           src_hit, take, last;
  logic [NSRC-1:0] live, wake_en;

  assign live = irq & USED;

  always_comb begin
    src_hit = 1'b0;
    src_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (live[i]) begin
        src_hit = 1'b1;
        src_idx = IW'(i + 2);
      end
  end

  assign take = insn_boundary && !iret && (sw_trap || (!i_mask && src_hit));
  assign last = (cnt == CW'(NCTX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_VHI;
      win <= '0;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (iret) st <= S_POP;
          else if (take) begin
            st  <= S_PUSH;
            win <= sw_trap ? IW'(1) : src_idx;
          end
        end
        S_PUSH: if (last) st <= S_VHI; else cnt <= cnt + 1'b1;
        S_VHI:  st <= S_VLO;
        S_VLO:  st <= S_IDLE;
        S_POP:  if (last) st <= S_IDLE; else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign stack_wr  = (st == S_PUSH);
  assign stack_rd  = (st == S_POP);
  assign stack_sel = (st == S_POP) ? CW'(NCTX - 1) - cnt : cnt;
  assign vec_rd    = (st == S_VHI) || (st == S_VLO);
  assign set_i     = (st == S_VHI);
  assign vec_addr  = VEC_TOP - AW'({win, 1'b0}) + AW'(st == S_VLO);

  assign wake_en = WAKE_SRC | (NSRC'(cfg_src2_wake) << 2);
  assign wake    = halted && (!rst_n || |(live & wake_en));
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int              NSRC    = 14,
  parameter int              AW      = 16,
  parameter logic [AW-1:0]   VEC_TOP = 16'hFFFE,
  parameter logic [NSRC-1:0] USED    = 14'h085F
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stack_wr,
  input logic          stack_rd,
  input logic [2:0]    stack_sel,
  input logic          vec_rd,
  input logic [AW-1:0] vec_addr,
  input logic          set_i,
  input logic          halted,
  input logic          wake
);
  localparam int IW = $clog2(NSRC + 2);
  localparam logic [NSRC+1:0] OK_SLOT = {USED, 2'b11};

  logic [AW-1:0] slot;
  assign slot = (VEC_TOP - {vec_addr[AW-1:1], 1'b0}) >> 1;

  assert_push_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_wr && stack_sel != 3'd4) |=> (stack_wr && stack_sel == $past(stack_sel) + 3'd1));

  assert_push_then_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_wr && stack_sel == 3'd4) |=> (vec_rd && !vec_addr[0] && set_i));

  assert_vector_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !vec_addr[0]) |=> (vec_rd && vec_addr[0] && !set_i &&
                                  vec_addr[AW-1:1] == $past(vec_addr[AW-1:1])));

  assert_pop_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_rd && stack_sel != 3'd0) |=> (stack_rd && stack_sel == $past(stack_sel) - 3'd1));

  assert_pop_no_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_rd && stack_sel == 3'd0) |=> !vec_rd);

  assert_used_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |-> (slot < AW'(NSRC + 2) && OK_SLOT[slot[IW-1:0]]));

  assert_one_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({stack_wr, stack_rd, vec_rd}) <= 1);

  assert_wake_needs_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> !wake);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.NSRC(NSRC), .AW(AW), .VEC_TOP(VEC_TOP), .USED(USED)) u_chk (
  .clk(clk), .rst_n(rst_n), .stack_wr(stack_wr), .stack_rd(stack_rd),
  .stack_sel(stack_sel), .vec_rd(vec_rd), .vec_addr(vec_addr), .set_i(set_i),
  .halted(halted), .wake(wake)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  localparam logic [13:0] USED = 14'h085F;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        insn_boundary = 1'b0, i_mask = 1'b0, sw_trap = 1'b0, iret = 1'b0;
  logic [13:0] irq = '0;
  logic        halted = 1'b0, cfg_src2_wake = 1'b0;
  logic        busy, stack_wr, stack_rd, vec_rd, set_i, wake;
  logic [2:0]  stack_sel;
  logic [15:0] vec_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .i_mask(i_mask),
    .sw_trap(sw_trap), .iret(iret), .irq(irq), .halted(halted),
    .cfg_src2_wake(cfg_src2_wake), .busy(busy), .stack_wr(stack_wr),
    .stack_rd(stack_rd), .stack_sel(stack_sel), .vec_rd(vec_rd),
    .vec_addr(vec_addr), .set_i(set_i), .wake(wake)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  function automatic int exp_slot(input logic [13:0] rq, input bit trap, input bit msk);
    if (trap) return 1;
    if (msk) return -1;
    for (int i = 0; i < 14; i++)
      if (rq[i] && USED[i]) return i + 2;
    return -1;
  endfunction

  function automatic logic [15:0] slot_addr(input int s);
    return 16'hFFFE - 16'(2 * s);
  endfunction

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic check_vector(input int s, input string req);
    chk(vec_rd && set_i && !stack_wr && !stack_rd && vec_addr == slot_addr(s), req, vec_addr, slot_addr(s));
    step();
    chk(vec_rd && !set_i && vec_addr == slot_addr(s) + 16'd1, req, vec_addr, slot_addr(s) + 16'd1);
    step();
    chk(!busy, req, busy, 0);
  endtask

  task automatic run_entry(input int s, input bit scramble);
    for (int k = 0; k < 5; k++) begin
      chk(stack_wr && !stack_rd && !vec_rd && stack_sel == 3'(k), "R5", stack_sel, k);
      if (scramble) irq = 14'($urandom);
      step();
    end
    check_vector(s, scramble ? "R8" : "R6");
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    step(); step();
    rst_n = 1'b1;
    chk(!stack_wr && !stack_rd, "R1", stack_wr, 0);
    check_vector(0, "R1");

    // R2: no boundary -> no entry
    irq = 14'h0001;
    step();
    chk(!busy, "R2", busy, 0);
    // R2: masked
    i_mask = 1'b1; insn_boundary = 1'b1;
    step();
    chk(!busy, "R2", busy, 0);
    // R3: trap beats mask and sources
    sw_trap = 1'b1;
    step();
    sw_trap = 1'b0; insn_boundary = 1'b0;
    run_entry(1, 0);
    // R7: only unused lines
    i_mask = 1'b0; irq = ~USED; insn_boundary = 1'b1;
    step();
    insn_boundary = 1'b0;
    chk(!busy, "R7", busy, 0);
    // R4: priority between 3 and 11
    irq = 14'h0808; insn_boundary = 1'b1;
    step();
    insn_boundary = 1'b0;
    run_entry(5, 0);
    // R8: scramble during sequence
    irq = 14'h0040; insn_boundary = 1'b1;
    step();
    insn_boundary = 1'b0;
    run_entry(8, 1);
    // R9: iret beats pending request
    irq = 14'h0001; insn_boundary = 1'b1; iret = 1'b1;
    step();
    iret = 1'b0; insn_boundary = 1'b0; irq = '0;
    for (int k = 4; k >= 0; k--) begin
      chk(stack_rd && !stack_wr && !vec_rd && stack_sel == 3'(k), "R9", stack_sel, k);
      step();
    end
    chk(!busy && !vec_rd, "R9", busy, 0);
    // R10: reset mid-push
    irq = 14'h0002; insn_boundary = 1'b1;
    step();
    insn_boundary = 1'b0;
    step();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1; irq = '0;
    chk(!stack_wr, "R10", stack_wr, 0);
    check_vector(0, "R10");
    // R11: wake
    halted = 1'b1; i_mask = 1'b1;
    irq = 14'h0008; #1; chk(!wake, "R11", wake, 0);
    irq = 14'h0001; #1; chk(wake, "R11", wake, 1);
    irq = 14'h0002; #1; chk(wake, "R11", wake, 1);
    irq = 14'h0004; #1; chk(!wake, "R11", wake, 0);
    cfg_src2_wake = 1'b1; #1; chk(wake, "R11", wake, 1);
    halted = 1'b0; #1; chk(!wake, "R11", wake, 0);
    irq = '0; cfg_src2_wake = 1'b0; i_mask = 1'b0;
    step();
    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [13:0] rq;
      bit tr, mk, bd;
      int s;
      rq = 14'($urandom);
      if ($urandom_range(0, 2) == 0) rq = rq & ~USED;
      tr = ($urandom_range(0, 7) == 0);
      mk = ($urandom_range(0, 3) == 0);
      bd = ($urandom_range(0, 5) != 0);
      irq = rq; sw_trap = tr; i_mask = mk; insn_boundary = bd;
      s = bd ? exp_slot(rq, tr, mk) : -1;
      step();
      insn_boundary = 1'b0; sw_trap = 1'b0;
      if (s < 0) chk(!busy, "R2", busy, 0);
      else run_entry(s, ($urandom_range(0, 1) == 1));
    end
    done = 1;
    finish_up();
  end
endmodule